// File: doc/BRIEF.md
# Three-Port Register File with Zero Register

This block holds the general-purpose registers of a small load/store processor. A single storage array is shared by two read ports and one write port. Each read port returns the addressed entry combinationally, so an operand is available within the same cycle as its address, with no clock edge in the path. The write port stores its data at the rising clock edge when its enable is high.

Entry zero is a constant: both read ports return all zeros for address zero, whatever has been written there. There is no write-through path. A read that targets the entry being written shows the previous contents until the edge and the new contents after it. Contents are undefined after power-up. The active-low reset clears no entry. While it is held, it blocks the write port.

Top module: `regfile3p`

## Requirements
- R1: Each read output follows its own read address combinationally. A new address gives the addressed entry's data before the next rising clock edge.
- R2: When `we_i` is high at a rising edge of `clk_i` with `rst_ni` high, `wdata_i` is stored at `waddr_i`. From that edge on, both read ports return the stored value for that address.
- R3: When `we_i` is low at a rising edge, no entry changes.
- R4: Address 0 on either read port returns all zeros at all times. This holds even after a write to address 0.
- R5: When a read address equals the write address in a writing cycle, the read port shows the old contents before the edge and the new contents after it. There is no bypass.
- R6: When both read ports select the same address, they return identical data.
- R7: While `rst_ni` is low, writes are suppressed: an edge with `we_i` high leaves the addressed entry unchanged.
- R8: A write changes only the entry at `waddr_i`. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes occur on its rising edge |
| rst_ni | input | 1 | Active-low reset; blocks writes while low, clears nothing |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| raddr_a_i | input | ADDR_W | Read address, port A |
| rdata_a_o | output | DATA_W | Read data, port A |
| raddr_b_i | input | ADDR_W | Read address, port B |
| rdata_b_o | output | DATA_W | Read data, port B |

## Verification
The hardest case to produce from the ports is a read of the very entry being written, sampled on both sides of the same edge. That sample is the only one that tells a bypass apart from the intended old-then-new behaviour. The bench holds read and write addresses equal across the edge and checks once before the edge and once after it. The table also writes nonzero data to address zero and then reads it on both ports. A final random phase runs on a fully initialised array with the enable toggling.

// File: rtl/rf_pkg.sv
package rf_pkg;
  function automatic int unsigned addr_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rf_wdec.sv
module rf_wdec #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic                     en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [NUM_ENTRIES-1:1]   sel_o
);
  // entry 0 has no storage, so it gets no select line
  for (genvar i = 1; i < NUM_ENTRIES; i++) begin : g_sel
    assign sel_o[i] = en_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 32
) (
  input  logic                          clk_i,
  input  logic [NUM_ENTRIES-1:1]        sel_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [NUM_ENTRIES*DATA_W-1:0] flat_o
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign flat_o[0 +: DATA_W] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i) begin
        if (sel_i[i]) q <= wdata_i;
      end
      assign flat_o[i*DATA_W +: DATA_W] = q;
    end
  end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic [NUM_ENTRIES*DATA_W-1:0] flat_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [DATA_W-1:0]             data_o
);
  // unmatched (out-of-range) addresses fall through to zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (addr_i == ADDR_W'(i)) data_o = flat_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/regfile3p.sv
module regfile3p #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned ADDR_W     = rf_pkg::addr_bits(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_ENTRIES-1:1]        sel;
  logic [NUM_ENTRIES*DATA_W-1:0] flat;
  logic [ADDR_W-1:0]             raddr [NUM_RD];
  logic [DATA_W-1:0]             rdata [NUM_RD];

  rf_wdec #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_wdec (
    .en_i   (we_i & rst_ni),
    .addr_i (waddr_i),
    .sel_o  (sel)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i   (clk_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .flat_o  (flat)
  );

  assign raddr[0] = raddr_a_i;
  assign raddr[1] = raddr_b_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_rdport #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_rd (
      .flat_i (flat),
      .addr_i (raddr[p]),
      .data_o (rdata[p])
    );
  end

  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];
endmodule

// File: rtl/regfile3p_chk.sv
module regfile3p_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned ADDR_W     = rf_pkg::addr_bits(NUM_ENTRIES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));

  a_r4_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));

  a_r6_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == raddr_b_i) |-> (rdata_a_o == rdata_b_o));

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=>
      ((raddr_a_i != $past(waddr_i)) || (rdata_a_o == $past(wdata_i))));

  a_r3_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (!$stable(raddr_a_i) || $stable(rdata_a_o)));
endmodule

bind regfile3p regfile3p_chk #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .waddr_i   (waddr_i),
  .wdata_i   (wdata_i),
  .raddr_a_i (raddr_a_i),
  .rdata_a_o (rdata_a_o),
  .raddr_b_i (raddr_b_i),
  .rdata_b_o (rdata_b_o)
);

// File: tb/sim_regfile3p.sv
`timescale 1ns/1ps
module sim_regfile3p;
  localparam int DW = 32;
  localparam int NE = 32;
  localparam int AW = 5;
  localparam int NV = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] waddr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [AW-1:0] raddr_a_i = '0;
  logic [AW-1:0] raddr_b_i = '0;
  logic [DW-1:0] rdata_a_o;
  logic [DW-1:0] rdata_b_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NE];
  bit            known [NE];

  always #2.5 clk_i = ~clk_i;

  regfile3p #(.DATA_W(DW), .NUM_ENTRIES(NE)) u0 (.*);

  // {we, waddr, wdata, raddr_a, raddr_b}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 5'd1,  32'h11111111, 5'd1,  5'd0},
    {1'b1, 5'd2,  32'hA5A5A5A5, 5'd1,  5'd2},
    {1'b1, 5'd3,  32'hDEADBEEF, 5'd3,  5'd3},
    {1'b0, 5'd3,  32'h00000000, 5'd3,  5'd2},
    {1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd0},
    {1'b1, 5'd1,  32'h22222222, 5'd1,  5'd1},
    {1'b0, 5'd2,  32'hFFFF0000, 5'd2,  5'd1},
    {1'b1, 5'd31, 32'h80000001, 5'd31, 5'd30},
    {1'b1, 5'd30, 32'h7FFFFFFE, 5'd31, 5'd30},
    {1'b0, 5'd30, 32'h00000000, 5'd30, 5'd31},
    {1'b1, 5'd16, 32'h0F0F0F0F, 5'd16, 5'd0},
    {1'b1, 5'd17, 32'hF0F0F0F0, 5'd16, 5'd17},
    {1'b1, 5'd0,  32'h12345678, 5'd17, 5'd0},
    {1'b0, 5'd16, 32'hFFFFFFFF, 5'd16, 5'd16},
    {1'b1, 5'd16, 32'h00000000, 5'd16, 5'd2},
    {1'b1, 5'd2,  32'h13579BDF, 5'd2,  5'd16}
  };

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input logic [AW-1:0] ra, input bit we, input logic [AW-1:0] wa);
    if (ra == 0) return "R4";
    if (we && wa == ra) return "R5";
    if (!we) return "R3";
    return "R2";
  endfunction

  task automatic chk_reads(input bit we, input logic [AW-1:0] wa);
    if (raddr_a_i == 0 || known[raddr_a_i])
      chk(rdata_a_o, (raddr_a_i == 0) ? '0 : model[raddr_a_i], tag(raddr_a_i, we, wa));
    if (raddr_b_i == 0 || known[raddr_b_i])
      chk(rdata_b_o, (raddr_b_i == 0) ? '0 : model[raddr_b_i], tag(raddr_b_i, we, wa));
    if (raddr_a_i == raddr_b_i) chk(rdata_a_o, rdata_b_o, "R6");
  endtask

  task automatic step(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb);
    @(negedge clk_i);
    we_i = we; waddr_i = wa; wdata_i = wd; raddr_a_i = ra; raddr_b_i = rb;
    #1 chk_reads(we, wa);
    @(posedge clk_i);
    if (we && rst_ni) begin model[wa] = wd; known[wa] = 1'b1; end
    #1 chk_reads(we, wa);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin model[i] = '0; known[i] = 1'b0; end
    // reset state: address 0 reads zero on both ports (R4)
    #1 chk(rdata_a_o, '0, "R4");
    chk(rdata_b_o, '0, "R4");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      step(VEC[v][47], VEC[v][46:42], VEC[v][41:10], VEC[v][9:5], VEC[v][4:0]);
    step(1'b0, '0, '0, 5'd0, 5'd0);

    // fill every entry, then check one write disturbs no other entry (R8)
    for (int a = 1; a < NE; a++) step(1'b1, AW'(a), {a[7:0], 8'h5A, ~a[7:0], 8'hC3}, AW'(a), 5'd0);
    step(1'b1, 5'd9, 32'hCAFEF00D, 5'd9, 5'd9);
    for (int a = 0; a < NE; a++) begin
      @(negedge clk_i); we_i = 1'b0; raddr_a_i = AW'(a); raddr_b_i = AW'((a + 1) % NE);
      #1 chk(rdata_a_o, (a == 0) ? '0 : model[a], "R8");
    end

    // R1: address changes with no clock edge in between
    @(negedge clk_i); we_i = 1'b0;
    raddr_a_i = 5'd9;  #0.3 chk(rdata_a_o, 32'hCAFEF00D, "R1");
    raddr_a_i = 5'd4;  #0.3 chk(rdata_a_o, model[4], "R1");
    raddr_b_i = 5'd31; #0.3 chk(rdata_b_o, model[31], "R1");

    // R7: write while reset held is suppressed
    @(negedge clk_i); rst_ni = 1'b0; we_i = 1'b1; waddr_i = 5'd5; wdata_i = 32'h0BADC0DE;
    @(posedge clk_i); #1;
    @(negedge clk_i); we_i = 1'b0; rst_ni = 1'b1; raddr_a_i = 5'd5; raddr_b_i = 5'd5;
    #1 chk(rdata_a_o, model[5], "R7");
    chk(rdata_b_o, model[5], "R7");

    // R4: nonzero write to entry 0 stays invisible
    step(1'b1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);

    // random phase on a fully initialised array
    for (int n = 0; n < 400; n++)
      step(1'($urandom), AW'($urandom), $urandom, AW'($urandom), AW'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule